// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects interrupt-worthy events from an Ethernet MAC and turns them into thirteen separate interrupt request lines. It keeps a 32-bit event register and a 32-bit mask register. Logic inside the MAC raises an event by giving its pulse input a single-cycle high. Software reads both registers through a plain register port. It acknowledges events by writing ones to the bits it wants cleared, and it chooses which events may interrupt by rewriting the mask.

Each event occupies a fixed bit in the upper thirteen bits of the event word. Each interrupt line carries one event class. The line order differs from the bit order, so the block routes each bit to its line. A line is high while its event bit and its mask bit are both set. The lines are registered. Alongside each line, the block gives a one-cycle toggle pulse whenever that line changes level, so a downstream edge-driven controller can see each transition.

Top module: `irq_evt_top`

## Requirements
- R1: After reset, the event register and the mask register both read zero, and every interrupt line and toggle pulse is low.
- R2: Pulse input index i sets one event bit, as follows: 0→bit 27, 1→26, 2→19, 3→20, 4→25, 5→24, 6→23, 7→21, 8→31, 9→28, 10→22, 11→29, 12→30. The bit reads back set from the cycle after the pulse.
- R3: A write with regSel=0 clears every event bit whose data bit is 1. Event bits written 0 keep their value.
- R4: A write with regSel=1 replaces all 32 bits of the mask. A read with regSel=1 returns the mask.
- R5: A read with regSel=0 returns the raw event bits, regardless of the mask.
- R6: Interrupt line i equals (event AND mask) at the bit that R2 gives for index i. It shows the value the registers held one clock earlier.
- R7: If a set pulse and a software clear reach the same event bit in one cycle, the bit ends up set.
- R8: irqToggle[i] is high for exactly the cycle in which irqLine[i] differs from its value in the previous cycle.
- R9: Event bits 18 to 0 always read zero, and neither writes nor pulses can set them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Register select: 0 event, 1 mask (read and write) |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the selected register (combinational) |
| evtPulse | input | 13 | Event set pulses, indexed in line order |
| irqLine | output | 13 | Registered interrupt lines |
| irqToggle | output | 13 | One-cycle pulse when the matching line changes |

## Verification
A hardware set pulse and a software write-one-to-clear can land on the same event bit in one cycle. The bench provokes this directly: it writes all ones to the event register while pulsing one input, and it expects that bit alone to survive. The random phase repeats the collision often, because it draws pulses and clearing writes independently each cycle. A bench model that applies the clear first and then the set judges every cycle. That model predicts the raw event word, the mask, each line one cycle later, and each toggle pulse.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_LINES = 13;

  // Strobes from control to datapath
  typedef struct packed {
    logic evtClr;
    logic maskLd;
  } regStrobe_t;

  // Event bit position carried by interrupt line idx
  function automatic int lineBit(input int idx);
    case (idx)
      0:  lineBit = 27;
      1:  lineBit = 26;
      2:  lineBit = 19;
      3:  lineBit = 20;
      4:  lineBit = 25;
      5:  lineBit = 24;
      6:  lineBit = 23;
      7:  lineBit = 21;
      8:  lineBit = 31;
      9:  lineBit = 28;
      10: lineBit = 22;
      11: lineBit = 29;
      default: lineBit = 30;
    endcase
  endfunction
endpackage

// File: rtl/irq_evt_dp.sv
module irq_evt_dp
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int LINES  = NUM_LINES
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINES-1:0]  evtPulse,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] activeVec
);
  localparam logic [DATA_W-1:0] EVT_FIELD =
    {{LINES{1'b1}}, {(DATA_W-LINES){1'b0}}};

  logic [DATA_W-1:0] evtReg, maskReg, setVec, clrVec, evtNext;

  always_comb begin
    setVec = '0;
    for (int i = 0; i < LINES; i++) setVec[lineBit(i)] = evtPulse[i];
  end

  assign clrVec  = strobe.evtClr ? wrData : '0;
  // clear applied first, then set: a pulse survives a same-cycle clear
  assign evtNext = ((evtReg & ~clrVec) | setVec) & EVT_FIELD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtReg  <= '0;
      maskReg <= '0;
    end else begin
      evtReg <= evtNext;
      if (strobe.maskLd) maskReg <= wrData;
    end
  end

  assign activeVec = evtReg & maskReg;
  assign rdData    = regSel ? maskReg : evtReg;

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.evtClr && evtPulse == '0) |=> ((evtReg & $past(wrData)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtPulse != '0) |=> ((evtReg & $past(setVec)) == $past(setVec)));

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.maskLd |=> (maskReg == $past(wrData)));

  // R9
  always_comb begin
    if (rstN) low_bits_zero_chk: assert ((evtReg & ~EVT_FIELD) == '0);
  end
endmodule

// File: rtl/irq_evt_ctrl.sv
module irq_evt_ctrl
  import irq_evt_pkg::*;
#(
  parameter int DATA_W = REG_W,
  parameter int LINES  = NUM_LINES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] activeVec,
  output regStrobe_t        strobe,
  output logic [LINES-1:0]  irqLine,
  output logic [LINES-1:0]  irqToggle
);
  logic [LINES-1:0] lineNext;

  always_comb begin
    strobe.evtClr = regWrEn && !regSel;
    strobe.maskLd = regWrEn && regSel;
  end

  always_comb begin
    for (int i = 0; i < LINES; i++) lineNext[i] = activeVec[lineBit(i)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLine   <= '0;
      irqToggle <= '0;
    end else begin
      irqLine   <= lineNext;
      irqToggle <= lineNext ^ irqLine;
    end
  end

  // R6
  line_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqLine == $past(lineNext)));

  // R8
  toggle_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (irqToggle == (irqLine ^ $past(irqLine))));

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.evtClr, strobe.maskLd}));
endmodule

// File: rtl/irq_evt_top.sv
module irq_evt_top
  import irq_evt_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regSel,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic [NUM_LINES-1:0] evtPulse,
  output logic [NUM_LINES-1:0] irqLine,
  output logic [NUM_LINES-1:0] irqToggle
);
  regStrobe_t       strobe;
  logic [REG_W-1:0] activeVec;

  irq_evt_ctrl #(.DATA_W(REG_W), .LINES(NUM_LINES)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .activeVec(activeVec), .strobe(strobe),
    .irqLine(irqLine), .irqToggle(irqToggle)
  );

  irq_evt_dp #(.DATA_W(REG_W), .LINES(NUM_LINES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regSel(regSel),
    .wrData(regWrData), .evtPulse(evtPulse),
    .rdData(regRdData), .activeVec(activeVec)
  );
endmodule

// File: tb/irq_evt_top_tb_top.sv
`timescale 1ns/1ps
module irq_evt_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [12:0] evtPulse = '0;
  logic [12:0] irqLine, irqToggle;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] evtM = '0, maskM = '0;
  logic [12:0] lineM = '0, togM = '0;

  localparam logic [31:0] EVT_F = 32'hFFF8_0000;

  always #5 clk = ~clk;

  irq_evt_top dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .evtPulse(evtPulse),
    .irqLine(irqLine), .irqToggle(irqToggle)
  );

  function automatic int posOf(input int i);
    int t [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    return t[i];
  endfunction

  function automatic logic [31:0] spread(input logic [12:0] p);
    logic [31:0] v = '0;
    for (int i = 0; i < 13; i++) v[posOf(i)] = p[i];
    return v;
  endfunction

  function automatic logic [12:0] gather(input logic [31:0] a);
    logic [12:0] v;
    for (int i = 0; i < 13; i++) v[i] = a[posOf(i)];
    return v;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at negedge: compare all observable state to the model
  task automatic checkAll();
    regWrEn = 1'b0;
    regSel = 1'b0; #1;
    check("R2/R3/R5/R7 event", regRdData, evtM);
    check("R9 low bits", regRdData & ~EVT_F, 32'h0);
    regSel = 1'b1; #1;
    check("R4 mask", regRdData, maskM);
    check("R6 lines", {19'h0, irqLine}, {19'h0, lineM});
    check("R8 toggle", {19'h0, irqToggle}, {19'h0, togM});
  endtask

  // Drive one cycle of stimulus at negedge, update model at edge, check
  task automatic step(input logic we, input logic sel, input logic [31:0] d,
                      input logic [12:0] p);
    logic [12:0] nl;
    logic [31:0] clr;
    regWrEn = we; regSel = sel; regWrData = d; evtPulse = p;
    @(posedge clk);
    nl = gather(evtM & maskM);
    togM = nl ^ lineM;
    lineM = nl;
    clr = (we && !sel) ? d : 32'h0;
    if (we && sel) maskM = d;
    evtM = ((evtM & ~clr) | spread(p)) & EVT_F;
    @(negedge clk);
    evtPulse = '0;
    checkAll();
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1D5E_0A73;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    checkAll();

    // R2 each pulse index sets its own bit; R5 raw read with mask zero
    for (int i = 0; i < 13; i++) step(1'b0, 1'b0, 32'h0, 13'(1 << i));
    check("R5 raw despite zero mask", evtM, 32'hFFF8_0000);
    // R4 mask replaces whole word, lines rise next cycle (R6)
    step(1'b1, 1'b1, 32'hA5A5_5A5A, '0);
    step(1'b0, 1'b0, 32'h0, '0);
    step(1'b1, 1'b1, 32'hFFFF_FFFF, '0);
    step(1'b0, 1'b0, 32'h0, '0);
    // R3 partial clear, zeros keep bits
    step(1'b1, 1'b0, 32'h0A00_0000, '0);
    // R7 clear-all collides with pulse on index 4 (bit 25)
    step(1'b1, 1'b0, 32'hFFFF_FFFF, 13'h010);
    check("R7 survivor", evtM, 32'h0200_0000);
    // R9 writes to low bits cannot set them
    step(1'b1, 1'b0, 32'h0007_FFFF, '0);
    step(1'b0, 1'b0, 32'h0, '0);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic we, sel;
      logic [12:0] p;
      we  = ($urandom % 3) == 0;
      sel = $urandom % 2;
      p   = 13'($urandom) & 13'($urandom) & 13'($urandom);
      step(we, sel, $urandom, p);
    end

    // reset mid-run returns to zero state (R1)
    rstN = 1'b0;
    @(posedge clk); @(negedge clk);
    evtM = '0; maskM = '0; lineM = '0; togM = '0;
    rstN = 1'b1;
    checkAll();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule